// File: doc/BRIEF.md
# Paired Set/Clear Core Control Register Bank

This block is a bank of memory-mapped control registers for a cluster of four processor cores. It sits on a simple 32-bit bus. The bus has a write strobe, a 12-bit byte address and a write data word. A combinational read data word always shows the register selected by the current address.

The bank holds four state vectors: core enable, per-core reset requests, isolation, and the power switch. Software never writes these vectors as whole words. Each vector has two addresses. Writing ones to the first address turns bits on, and writing ones to the second turns bits off. A write to one of these addresses never needs a read-modify-write beforehand.

The bank also has one ordinary read/write peripheral control word. Its top four bits mask the wait-for-interrupt signal of each core. Every stored bit that belongs to a core is driven straight onto a dedicated output port. The block does no sequencing and no timing of its own.

Top module: `core_ctl_regs`

## Requirements
- R1: After a synchronous reset (`rst` high at a clock edge) the bank holds these values:
  - core enable = 0x0000_0001 (core 0 on, cores 1 to 3 off);
  - reset requests = 0x0380_E0EE (every request asserted except core 0's);
  - isolation = 0x0000_0060 (cores 2 and 3 isolated);
  - power switch = 0x0000_0000;
  - peripheral control = 0x0000_0000.
- R2: A write to the set address of a vector stores a 1 in every implemented bit where the data has a 1. Bits where the data has a 0 keep their value. The change is visible from the clock edge that takes the write. The set/clear address pairs are:
  - isolation: 0x0C0 / 0x0C4;
  - power switch: 0x0D0 / 0x0D4;
  - core enable: 0x0F4 / 0x0F8;
  - reset requests: 0x410 / 0x414.
- R3: A write to the clear address of a vector stores a 0 in every bit where the data has a 1. Bits where the data has a 0 keep their value.
- R4: A read of either address of a pair returns the current stored vector.
- R5: Only certain bits of each vector exist. All other bits read as 0, and writes to them have no effect. The implemented bits are:
  - core enable: bit c for core c;
  - reset requests: bits 0+c (core), 4+c (vector unit), 12+c (debug) and 22+c (monitor) for core c;
  - isolation and power switch: bits 5 and 6 only, for cores 2 and 3.
- R6: Address 0x200 is a plain 32-bit read/write register. A write replaces all 32 bits. Bit 28+c is the wait-for-interrupt mask of core c.
- R7: Any other address reads as 0, including addresses that are not word aligned. A write to such an address changes no register.
- R8: The output ports always equal their stored bits:
  - `core_en_o[c]` is core-enable bit c;
  - `rst_core_o`, `rst_vec_o`, `rst_dbg_o` and `rst_mon_o` carry reset-request bits 0+c, 4+c, 12+c and 22+c;
  - `iso_o[j]` and `pwr_o[j]` carry bit 5+j of their vectors, for core 2+j;
  - `wfi_mask_o[c]` is peripheral bit 28+c.
- R9: A vector that is not addressed by a write keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the current address |
| addr | input | 12 | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for the current address (combinational) |
| core_en_o | output | 4 | Core enable per core |
| rst_core_o | output | 4 | Core reset request per core |
| rst_vec_o | output | 4 | Vector-unit reset request per core |
| rst_dbg_o | output | 4 | Debug reset request per core |
| rst_mon_o | output | 4 | Monitor reset request per core |
| iso_o | output | 2 | Isolation for cores 2 and 3 |
| pwr_o | output | 2 | Power switch for cores 2 and 3 |
| wfi_mask_o | output | 4 | Wait-for-interrupt mask per core |

## Verification
The embedded assertions check on every cycle that a set write raises exactly the addressed bits, that a clear write drops them, and that bits written with zero are kept. They also check that an unaddressed vector holds and that a write to an unmapped address disturbs nothing. The bench alone can show the reset values, the bit positions that each pair implements, the read-back through both addresses, and the mapping of stored bits onto the output ports. It sweeps every bit of every pair, sweeps every word address of the space, and tries unaligned addresses.

// File: rtl/cctl_pkg.sv
package cctl_pkg;
    localparam int DW      = 32;
    localparam int AW      = 12;
    localparam int NCORE   = 4;
    localparam int NVEC    = 4;
    localparam int NSW     = 2;   // cores with power switch and isolation
    localparam int SW_BIT0 = 5;

    // vector indices
    localparam int V_ISO = 0;
    localparam int V_PWR = 1;
    localparam int V_CEN = 2;
    localparam int V_RST = 3;

    // reset request field bases
    localparam int RB_CORE = 0;
    localparam int RB_VEC  = 4;
    localparam int RB_DBG  = 12;
    localparam int RB_MON  = 22;
    localparam int WFI_BIT0 = 28;

    localparam logic [AW-1:0] PER_OFS = 12'h200;

    typedef struct packed {
        logic [NVEC-1:0] set_hit;
        logic [NVEC-1:0] clr_hit;
        logic            per_hit;
    } dec_t;

    function automatic logic [AW-1:0] set_ofs(input int k);
        case (k)
            V_ISO:   return 12'h0C0;
            V_PWR:   return 12'h0D0;
            V_CEN:   return 12'h0F4;
            default: return 12'h410;
        endcase
    endfunction

    function automatic logic [AW-1:0] clr_ofs(input int k);
        return set_ofs(k) + ((k == V_CEN) ? 12'h004 : 12'h004);
    endfunction

    function automatic logic [DW-1:0] vec_mask(input int k);
        logic [DW-1:0] m;
        m = '0;
        for (int c = 0; c < NCORE; c++) begin
            case (k)
                V_ISO, V_PWR: if (c >= NCORE - NSW) m[SW_BIT0 + c - (NCORE - NSW)] = 1'b1;
                V_CEN:        m[c] = 1'b1;
                default: begin
                    m[RB_CORE + c] = 1'b1;
                    m[RB_VEC + c]  = 1'b1;
                    m[RB_DBG + c]  = 1'b1;
                    m[RB_MON + c]  = 1'b1;
                end
            endcase
        end
        return m;
    endfunction

    function automatic logic [DW-1:0] vec_reset(input int k);
        logic [DW-1:0] r;
        case (k)
            V_ISO:   r = vec_mask(V_ISO);
            V_PWR:   r = '0;
            V_CEN:   r = {{(DW-1){1'b0}}, 1'b1};
            default: r = vec_mask(V_RST) & ~((DW'(1) << RB_CORE) | (DW'(1) << RB_VEC)
                                           | (DW'(1) << RB_DBG)  | (DW'(1) << RB_MON));
        endcase
        return r;
    endfunction
endpackage

// File: rtl/cctl_dec.sv
module cctl_dec
    import cctl_pkg::*;
(
    input  logic [AW-1:0] addr,
    output dec_t          hit
);
    for (genvar k = 0; k < NVEC; k++) begin : g_pair
        assign hit.set_hit[k] = (addr == set_ofs(k));
        assign hit.clr_hit[k] = (addr == clr_ofs(k));
    end
    assign hit.per_hit = (addr == PER_OFS);
endmodule

// File: rtl/cctl_sc_vec.sv
module cctl_sc_vec
    import cctl_pkg::*;
#(
    parameter logic [DW-1:0] MASK = '1,
    parameter logic [DW-1:0] RSTV = '0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          set_we,
    input  logic          clr_we,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= RSTV & MASK;
        else if (set_we)
            q <= (q | wdata) & MASK;
        else if (clr_we)
            q <= q & ~wdata;
    end

    assert_set_R2: assert property (@(posedge clk) disable iff (rst)
        set_we |=> ((q & $past(wdata) & MASK) == ($past(wdata) & MASK)));
    assert_clr_R3: assert property (@(posedge clk) disable iff (rst)
        (clr_we && !set_we) |=> ((q & $past(wdata)) == '0));
    assert_keep_zero_R2: assert property (@(posedge clk) disable iff (rst)
        (set_we || clr_we) |=> ((q & ~$past(wdata)) == ($past(q) & ~$past(wdata))));
    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (!set_we && !clr_we) |=> $stable(q));
endmodule

// File: rtl/core_ctl_regs.sv
module core_ctl_regs
    import cctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [AW-1:0]     addr,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rdata,
    output logic [NCORE-1:0]  core_en_o,
    output logic [NCORE-1:0]  rst_core_o,
    output logic [NCORE-1:0]  rst_vec_o,
    output logic [NCORE-1:0]  rst_dbg_o,
    output logic [NCORE-1:0]  rst_mon_o,
    output logic [NSW-1:0]    iso_o,
    output logic [NSW-1:0]    pwr_o,
    output logic [NCORE-1:0]  wfi_mask_o
);
    dec_t                      hit;
    logic [NVEC-1:0][DW-1:0]   vec;
    logic [DW-1:0]             per_q;

    cctl_dec u_dec (.addr(addr), .hit(hit));

    for (genvar k = 0; k < NVEC; k++) begin : g_vec
        cctl_sc_vec #(.MASK(vec_mask(k)), .RSTV(vec_reset(k))) u_vec (
            .clk   (clk),
            .rst   (rst),
            .set_we(wr_en & hit.set_hit[k]),
            .clr_we(wr_en & hit.clr_hit[k]),
            .wdata (wdata),
            .q     (vec[k])
        );
    end

    always_ff @(posedge clk) begin
        if (rst)
            per_q <= '0;
        else if (wr_en && hit.per_hit)
            per_q <= wdata;
    end

    always_comb begin
        rdata = '0;
        for (int k = 0; k < NVEC; k++)
            if (hit.set_hit[k] || hit.clr_hit[k])
                rdata = vec[k];
        if (hit.per_hit)
            rdata = per_q;
    end

    for (genvar c = 0; c < NCORE; c++) begin : g_core
        assign core_en_o[c]  = vec[V_CEN][c];
        assign rst_core_o[c] = vec[V_RST][RB_CORE + c];
        assign rst_vec_o[c]  = vec[V_RST][RB_VEC + c];
        assign rst_dbg_o[c]  = vec[V_RST][RB_DBG + c];
        assign rst_mon_o[c]  = vec[V_RST][RB_MON + c];
        assign wfi_mask_o[c] = per_q[WFI_BIT0 + c];
    end

    for (genvar j = 0; j < NSW; j++) begin : g_sw
        assign iso_o[j] = vec[V_ISO][SW_BIT0 + j];
        assign pwr_o[j] = vec[V_PWR][SW_BIT0 + j];
    end

    assert_dec_onehot_R7: assert property (@(posedge clk) disable iff (rst)
        $onehot0({hit.set_hit, hit.clr_hit, hit.per_hit}));
    assert_unmapped_R7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !(|{hit.set_hit, hit.clr_hit, hit.per_hit})) |=> ($stable(vec) && $stable(per_q)));
    assert_per_wr_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && hit.per_hit) |=> (wfi_mask_o == $past(wdata[WFI_BIT0 +: NCORE])));
endmodule

// File: tb/core_ctl_regs_test.sv
`timescale 1ns/1ps
module core_ctl_regs_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [3:0]  core_en_o, rst_core_o, rst_vec_o, rst_dbg_o, rst_mon_o, wfi_mask_o;
    logic [1:0]  iso_o, pwr_o;

    int n_chk = 0;
    int n_err = 0;
    logic [31:0] m [5];   // 0 iso, 1 pwr, 2 core enable, 3 reset req, 4 peripheral

    always #2.5 clk = ~clk;

    core_ctl_regs uut (.*);

    function automatic logic [11:0] sa(input int k);
        case (k) 0: return 12'h0C0; 1: return 12'h0D0; 2: return 12'h0F4; 3: return 12'h410;
                 default: return 12'h200; endcase
    endfunction
    function automatic logic [11:0] ca(input int k);
        return (k == 4) ? 12'h200 : sa(k) + 12'h4;
    endfunction
    function automatic logic [31:0] mk(input int k);
        logic [31:0] r = 0;
        for (int c = 0; c < 4; c++) begin
            if (k == 2) r |= 32'h1 << c;
            if (k == 3) r |= (32'h1 << c) | (32'h1 << (4 + c)) | (32'h1 << (12 + c)) | (32'h1 << (22 + c));
        end
        if (k < 2) r = 32'h60;
        if (k == 4) r = '1;
        return r;
    endfunction
    function automatic bit mapped(input logic [11:0] a);
        for (int k = 0; k < 5; k++) if (a == sa(k) || a == ca(k)) return 1;
        return 0;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
        addr = a; #1;
        chk(rdata === exp, tag, rdata, exp);
    endtask

    task automatic chk_ports();
        logic [31:0] act, exp;
        exp = 0; act = 0;
        for (int c = 0; c < 4; c++) begin
            exp[c] = m[2][c];        act[c] = core_en_o[c];
            exp[4+c] = m[3][c];      act[4+c] = rst_core_o[c];
            exp[8+c] = m[3][4+c];    act[8+c] = rst_vec_o[c];
            exp[12+c] = m[3][12+c];  act[12+c] = rst_dbg_o[c];
            exp[16+c] = m[3][22+c];  act[16+c] = rst_mon_o[c];
            exp[20+c] = m[4][28+c];  act[20+c] = wfi_mask_o[c];
        end
        exp[25:24] = m[0][6:5]; act[25:24] = iso_o;
        exp[27:26] = m[1][6:5]; act[27:26] = pwr_o;
        chk(act === exp, "R8 ports", act, exp);
    endtask

    task automatic chk_all(input string tag);
        for (int k = 0; k < 5; k++) begin
            rd(sa(k), m[k], tag);
            rd(ca(k), m[k], tag);
        end
        chk_ports();
    endtask

    initial begin
        #1_000_000;
        n_err++;
        $display("FAIL watchdog act=%h exp=%h", 32'h1, 32'h0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        m[0] = 32'h60; m[1] = 0; m[2] = 32'h1; m[3] = 32'h0380E0EE; m[4] = 0;
        chk_all("R1 reset value");

        // R2/R3/R5/R9: sweep every bit through set then clear, on every pair
        for (int k = 0; k < 4; k++) begin
            for (int b = 0; b < 32; b++) begin
                wr(sa(k), 32'h1 << b);
                m[k] |= (32'h1 << b) & mk(k);
                rd(sa(k), m[k], "R2 R5 set bit");
                rd(ca(k), m[k], "R4 read clear alias");
                chk_ports();
            end
            for (int b = 0; b < 32; b++) begin
                wr(ca(k), 32'h1 << b);
                m[k] &= ~(32'h1 << b);
                rd(ca(k), m[k], "R3 clear bit");
            end
            chk_all("R9 others hold");
            wr(sa(k), 32'hA5A5A5A5); m[k] |= 32'hA5A5A5A5 & mk(k);
            chk_all("R2 pattern");
            wr(ca(k), 32'h0F0F0F0F); m[k] &= ~32'h0F0F0F0F;
            chk_all("R3 pattern");
            wr(sa(k), 32'h0); chk_all("R2 zero set keeps");
            wr(ca(k), 32'h0); chk_all("R3 zero clear keeps");
        end

        // R6 plain register and wait-for-interrupt mask bits
        foreach (m[i]) if (i == 4) begin
            for (int c = 0; c < 4; c++) begin
                wr(12'h200, 32'h1 << (28 + c)); m[4] = 32'h1 << (28 + c);
                chk_all("R6 wfi bit");
            end
            wr(12'h200, 32'h5A3C_0F96); m[4] = 32'h5A3C_0F96; chk_all("R6 full word");
        end

        // R7 unmapped sweep, plus unaligned addresses
        for (int a = 0; a < 4096; a += 4) begin
            if (!mapped(12'(a))) begin
                wr(12'(a), 32'hFFFF_FFFF);
                rd(12'(a), 32'h0, "R7 unmapped read");
            end
        end
        wr(12'h0C1, 32'hFFFF_FFFF); rd(12'h0C1, 0, "R7 unaligned");
        wr(12'h202, 32'h0);         rd(12'h202, 0, "R7 unaligned");
        wr(12'h416, 32'hFFFF_FFFF);
        chk_all("R7 writes ignored");

        // reset again returns to R1 values
        @(negedge clk); rst = 1'b1; @(negedge clk); rst = 1'b0;
        m[0] = 32'h60; m[1] = 0; m[2] = 32'h1; m[3] = 32'h0380E0EE; m[4] = 0;
        chk_all("R1 re-reset");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
        $finish;
    end
endmodule